// File: doc/BRIEF.md
# Single-Wire Slave Reset and Slot Timing

This block is the bit-level signalling layer of a slave on an open-drain single-wire bus. It receives the raw bus level, re-times it through a two-flop synchroniser, and measures every low pulse that the master produces. Each low pulse is classified either as a reset or as a one-bit time slot.

After a reset, the block answers with a presence pulse. In write slots it samples the line at a fixed point after the falling edge and strobes the received bit upward. In read slots where the upper layer sends a zero, it holds the line low for a fixed time. A separate pin pulls the line low; the bus itself is open-drain.

The block keeps a speed flag for standard or overdrive timing. All durations are cycle counts derived from a cycles-per-microsecond parameter. The upper layer asks for overdrive with a one-cycle request, and the request takes effect at the next slot boundary. Reset pulses move the speed back to standard or keep it in overdrive, depending on their length.

Because every slot is sampled, the low phase of a reset pulse also produces one bit strobe at the sample point. The upper layer drops that bit when the reset event follows.

Top module: `sw_slave_phy`

## Requirements
- R1: After `rst_n` is released with the line idle high, `pull_low`, `rx_valid`, `reset_evt` and `od_active` are all 0.
- R2: At standard speed, a master low shorter than 30 µs yields one `rx_valid` pulse with `rx_bit`=1. A low from 30 µs up to 100 µs yields one pulse with `rx_bit`=0. In both cases there is no `reset_evt`.
- R3: At standard speed, a low longer than 120 µs produces one single-cycle `reset_evt` when the line rises, and `od_active` stays 0.
- R4: In overdrive, a low longer than 16 µs and no longer than 80 µs produces `reset_evt`, and `od_active` stays 1.
- R5: In overdrive, a low longer than 80 µs, including 480 µs and more, produces `reset_evt` and sets `od_active` to 0.
- R6: After a reset pulse ends, `pull_low` goes high after about 15 µs at standard speed (2 µs in overdrive). It then stays high for exactly 120 µs (12 µs in overdrive), using the speed that the reset selected.
- R7: With `tx_mode`=1 and `tx_bit`=0, the falling edge of a slot makes `pull_low` high for exactly 30 µs at standard speed (3 µs in overdrive). With `tx_bit`=1, `pull_low` stays 0. `rx_bit` then reflects the bus level, so it reads 0 and 1 respectively.
- R8: A one-cycle `od_set` pulse sets `od_active` to 1 only once no slot is in progress. A request made during a slot takes effect after that slot ends.
- R9: In overdrive, write slots are sampled 3 µs after the falling edge: a 1 µs low reads 1 and an 8 µs low reads 0.
- R10: `reset_evt` and `rx_valid` are single-cycle pulses and are never high in the same cycle. `od_active` falls only in the cycle of a `reset_evt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_raw | input | 1 | Asynchronous bus level (1 = high) |
| od_set | input | 1 | One-cycle request to enter overdrive |
| tx_mode | input | 1 | 1 = next slot is a read slot driven by this slave |
| tx_bit | input | 1 | Bit to send in a read slot |
| rx_valid | output | 1 | One-cycle strobe: sampled slot bit is valid |
| rx_bit | output | 1 | Sampled line level of the last slot |
| reset_evt | output | 1 | One-cycle strobe: a reset pulse ended |
| pull_low | output | 1 | Open-drain enable; 1 pulls the line low |
| od_active | output | 1 | 1 = overdrive timings in use |

## Verification
A wrong slot counter or a wrong speed flag first shows as an `rx_bit` of the wrong value at the sample strobe, within one slot of the fault. The pulse classifier is checked at the ports of the block. A threshold error turns a long low into a bit strobe without `reset_evt`, or turns a short one into a reset that is followed by a presence pulse. The wrong outcome is visible within about 135 µs of the line rising. A wrong speed decision after a reset changes the length of the presence pulse by a factor of ten, so every reset case also measures that pulse to the cycle.

// File: rtl/swp_pkg.sv
// Shared types for the single-wire slave physical layer.
// Assumes: nothing beyond IEEE 1800-2017.
package swp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SLOT   = 3'd1,
        ST_PWAIT  = 3'd2,
        ST_PDRIVE = 3'd3,
        ST_PEND   = 3'd4
    } swp_state_t;
endpackage

// File: rtl/swp_sync.sv
// Multi-stage synchroniser for the asynchronous bus level.
// Assumes: the line idles high, so every stage resets to 1.
module swp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Stage i: re-time the previous stage (or the pin for stage 0).
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else if (i == 0) chain[i] <= d_in;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/swp_speed.sv
// Speed flag holder: standard (0) or overdrive (1).
// Assumes: rst_now is a one-cycle pulse at the end of a reset pulse and
// keep_od gives the speed chosen by that reset; an od_set request stays
// pending until the slot engine reports that it is idle.
module swp_speed (
    input  logic clk,
    input  logic rst_n,
    input  logic od_set,
    input  logic idle,
    input  logic rst_now,
    input  logic keep_od,
    output logic od
);
    logic pend;

    // Update the speed from reset pulses and from pending overdrive requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            od   <= 1'b0;
            pend <= 1'b0;
        end else if (rst_now) begin
            od   <= keep_od;
            pend <= 1'b0;
        end else if (pend && idle) begin
            od   <= 1'b1;
            pend <= 1'b0;
        end else if (od_set) begin
            pend <= 1'b1;
        end
    end
endmodule

// File: rtl/sw_slave_phy.sv
// Single-wire slave physical layer. It times low pulses on the synchronised
// line, classifies them as reset or slot, drives presence and read-zero pulses,
// and samples write slots.
// Assumes: CYC_PER_US clock cycles per microsecond; line_raw is asynchronous.
module sw_slave_phy
    import swp_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    input  logic od_set,
    input  logic tx_mode,
    input  logic tx_bit,
    output logic rx_valid,
    output logic rx_bit,
    output logic reset_evt,
    output logic pull_low,
    output logic od_active
);
    localparam int CW = $clog2(121 * CYC_PER_US + 2);
    localparam logic [CW-1:0] CMAX       = '1;
    localparam logic [CW-1:0] K_ST_RST   = CW'(120 * CYC_PER_US);
    localparam logic [CW-1:0] K_OD_RST   = CW'(16 * CYC_PER_US);
    localparam logic [CW-1:0] K_OD_KEEP  = CW'(80 * CYC_PER_US);
    localparam logic [CW-1:0] K_ST_SAMP  = CW'(30 * CYC_PER_US);
    localparam logic [CW-1:0] K_OD_SAMP  = CW'(3 * CYC_PER_US);
    localparam logic [CW-1:0] K_ST_HOLD  = CW'(30 * CYC_PER_US);
    localparam logic [CW-1:0] K_OD_HOLD  = CW'(3 * CYC_PER_US);
    localparam logic [CW-1:0] K_ST_PDH   = CW'(15 * CYC_PER_US);
    localparam logic [CW-1:0] K_OD_PDH   = CW'(2 * CYC_PER_US);
    localparam logic [CW-1:0] K_ST_PDL   = CW'(120 * CYC_PER_US);
    localparam logic [CW-1:0] K_OD_PDL   = CW'(12 * CYC_PER_US);

    swp_state_t     state;
    logic [CW-1:0]  cnt;
    logic           line_s, line_q, drive0;
    logic           fall, rise, rst_now, keep_od;
    logic [CW-1:0]  t_samp, t_hold, t_pdh, t_pdl;

    swp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(line_raw), .d_out(line_s)
    );

    swp_speed u_speed (
        .clk(clk), .rst_n(rst_n), .od_set(od_set),
        .idle(state == ST_IDLE), .rst_now(rst_now),
        .keep_od(keep_od), .od(od_active)
    );

    // Pick the timing set for the current speed.
    always_comb begin
        t_samp = od_active ? K_OD_SAMP : K_ST_SAMP;
        t_hold = od_active ? K_OD_HOLD : K_ST_HOLD;
        t_pdh  = od_active ? K_OD_PDH  : K_ST_PDH;
        t_pdl  = od_active ? K_OD_PDL  : K_ST_PDL;
    end

    // Edge detection and reset classification of the low pulse just ended.
    always_comb begin
        fall    = line_q & ~line_s;
        rise    = ~line_q & line_s;
        rst_now = (state == ST_SLOT) && rise &&
                  (od_active ? (cnt > K_OD_RST) : (cnt > K_ST_RST));
        keep_od = od_active && (cnt <= K_OD_KEEP);
    end

    // Open-drain enable: presence pulse, or the read-zero hold window.
    always_comb begin
        pull_low = (state == ST_PDRIVE) ||
                   ((state == ST_SLOT) && drive0 && (cnt <= t_hold));
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_s;
    end

    // Slot and presence sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            drive0    <= 1'b0;
            rx_valid  <= 1'b0;
            rx_bit    <= 1'b1;
            reset_evt <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            reset_evt <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fall) begin
                        state  <= ST_SLOT;
                        cnt    <= CW'(1);
                        drive0 <= tx_mode & ~tx_bit;
                    end
                end
                ST_SLOT: begin
                    cnt <= (cnt == CMAX) ? cnt : cnt + 1'b1;
                    if (cnt == t_samp) begin
                        rx_valid <= 1'b1;
                        rx_bit   <= line_s;
                    end
                    if (rst_now) begin
                        state     <= ST_PWAIT;
                        cnt       <= '0;
                        drive0    <= 1'b0;
                        reset_evt <= 1'b1;
                    end else if (line_s && (cnt > t_samp)) begin
                        state  <= ST_IDLE;
                        drive0 <= 1'b0;
                    end
                end
                ST_PWAIT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == t_pdh - 1'b1) begin
                        state <= ST_PDRIVE;
                        cnt   <= '0;
                    end
                end
                ST_PDRIVE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == t_pdl - 1'b1) state <= ST_PEND;
                end
                ST_PEND: begin
                    if (line_s) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swp_checker.sv
// Protocol checker for sw_slave_phy, attached by bind.
// Assumes: it observes the ports and the sequencer state only.
module swp_checker
    import swp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input swp_state_t state,
    input logic       rx_valid,
    input logic       reset_evt,
    input logic       pull_low,
    input logic       od_active
);
    a_r10_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        reset_evt |=> !reset_evt);
    a_r10_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && reset_evt));
    a_r10_od_fall_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_active) |-> reset_evt);
    a_r8_od_rise_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_active) |-> $past(state == ST_IDLE));
    a_r7_pull_never_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> (state != ST_IDLE));
endmodule

bind sw_slave_phy swp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .rx_valid(rx_valid),
    .reset_evt(reset_evt), .pull_low(pull_low), .od_active(od_active)
);

// File: tb/sim_sw_slave_phy.sv
module sim_sw_slave_phy;
    localparam int CPU = 2;
    localparam int NV  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mlow = 1'b0;
    logic od_set = 1'b0, tx_mode = 1'b0, tx_bit = 1'b1;
    logic rx_valid, rx_bit, reset_evt, pull_low, od_active;
    logic line_raw;
    int checks = 0, errors = 0;
    int rxn = 0, rstn_cnt = 0, pullc = 0;
    logic lastbit = 1'b1;

    always #2 clk = ~clk;
    assign line_raw = ~(mlow | pull_low);

    sw_slave_phy #(.CYC_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .line_raw(line_raw), .od_set(od_set),
        .tx_mode(tx_mode), .tx_bit(tx_bit), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .reset_evt(reset_evt), .pull_low(pull_low),
        .od_active(od_active)
    );

    // Port monitor, sampled on the falling clock edge.
    always @(negedge clk) begin
        if (rx_valid) begin rxn++; lastbit = rx_bit; end
        if (reset_evt) rstn_cnt++;
        if (pull_low) pullc++;
    end

    // vector: {od_before, low_us, expect_reset, expect_od_after, expect_bit}
    typedef struct packed { logic od; int us; logic er; logic eo; logic eb; } vec_t;
    localparam vec_t VECS [NV] = '{
        '{1'b0,   2, 1'b0, 1'b0, 1'b1},   // R2 write one
        '{1'b0,  60, 1'b0, 1'b0, 1'b0},   // R2 write zero
        '{1'b0, 100, 1'b0, 1'b0, 1'b0},   // R2 long slot, not reset
        '{1'b0, 130, 1'b1, 1'b0, 1'b0},   // R3 std reset
        '{1'b0, 500, 1'b1, 1'b0, 1'b0},   // R3 long std reset
        '{1'b1,   1, 1'b0, 1'b1, 1'b1},   // R9 od write one
        '{1'b1,   8, 1'b0, 1'b1, 1'b0},   // R9 od write zero
        '{1'b1,  50, 1'b1, 1'b1, 1'b0},   // R4 od short reset keeps od
        '{1'b1, 200, 1'b1, 1'b0, 1'b0},   // R5 od mid reset to std
        '{1'b1, 500, 1'b1, 1'b0, 1'b0}    // R5 od long reset to std
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic low_pulse(input int us);
        @(negedge clk); mlow = 1'b1;
        cyc(us * CPU);
        mlow = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        rxn = 0; rstn_cnt = 0; pullc = 0;
    endtask

    task automatic set_speed(input logic o);
        if (o && !od_active) begin
            @(negedge clk); od_set = 1'b1;
            @(negedge clk); od_set = 1'b0;
            cyc(4);
        end else if (!o && od_active) begin
            low_pulse(500);
            cyc(400 * CPU);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int d;
        int pdh, pdl;
        set_speed(v.od);
        clear_mon();
        low_pulse(v.us);
        if (v.er) begin
            pdh = v.eo ? 2 * CPU : 15 * CPU;
            pdl = v.eo ? 12 * CPU : 120 * CPU;
            d = 0;
            while (!pull_low && d < 4000) begin @(negedge clk); d++; end
            cyc(pdl + 20);
            check(rstn_cnt == 1, v.eo ? "R4 reset count" : "R3/R5 reset count", rstn_cnt, 1);
            check(od_active == v.eo, v.eo ? "R4 speed kept" : "R3/R5 speed std", od_active, v.eo);
            check(pullc == pdl, "R6 presence length", pullc, pdl);
            check(d >= pdh && d <= pdh + 6, "R6 presence delay", d, pdh);
        end else begin
            cyc(100);
            check(rxn == 1, v.od ? "R9 strobe count" : "R2 strobe count", rxn, 1);
            check(lastbit == v.eb, v.od ? "R9 bit" : "R2 bit", lastbit, v.eb);
            check(rstn_cnt == 0, "R2 no reset", rstn_cnt, 0);
        end
    endtask

    task automatic read_slot(input logic b, input int hold, input string tag);
        tx_mode = 1'b1; tx_bit = b;
        clear_mon();
        low_pulse(1);
        cyc(40 * CPU);
        tx_mode = 1'b0; tx_bit = 1'b1;
        check(pullc == (b ? 0 : hold), tag, pullc, b ? 0 : hold);
        check(lastbit == b && rxn == 1, tag, lastbit, b);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(5);
        // R1 reset state
        check(!pull_low && !rx_valid && !reset_evt, "R1 outputs idle", pull_low, 0);
        check(od_active == 1'b0, "R1 standard speed", od_active, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7 read slots at both speeds
        set_speed(1'b0);
        read_slot(1'b0, 30 * CPU, "R7 std read zero");
        read_slot(1'b1, 30 * CPU, "R7 std read one");
        set_speed(1'b1);
        read_slot(1'b0, 3 * CPU, "R7 od read zero");

        // R8 overdrive request during a slot waits for the slot to end
        set_speed(1'b0);
        @(negedge clk); mlow = 1'b1;
        cyc(20 * CPU);
        od_set = 1'b1; @(negedge clk); od_set = 1'b0;
        cyc(10 * CPU);
        check(od_active == 1'b0, "R8 no change mid slot", od_active, 0);
        cyc(20 * CPU);
        mlow = 1'b0;
        cyc(20);
        check(od_active == 1'b1, "R8 applied after slot", od_active, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule